// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable, clock-synchronous model of the device side of a three-wire serial EEPROM. A host raises chip select, toggles a serial clock and presents a bit stream on the data input. The block waits for a start bit of 1. It then collects a two-bit opcode and an address field, and for write commands a data field. It reads, writes or erases an internal register array, and it also handles the array-wide erase, the array-wide write, and the write-enable and write-disable commands. All pins are sampled with the system clock `clk`, and the serial clock is treated as an ordinary input whose rising edges are detected.

A configuration input selects the array width at run time. In word mode the array holds 16-bit locations. In byte mode it holds twice as many 8-bit locations, which takes one more address bit. Program commands take effect when chip select falls. A cycle counter then holds the device busy for a time that depends on the command. While chip select is high during and after that time, the serial output reports busy as 0 and ready as 1. A program-enable input and a software-set enable latch must both allow a program command before it has any effect.

Top module: `mw_eeprom`

## Requirements
- R1: Serial input is sampled on rising `sck` edges while `cs` is high, most significant bit first. Zeros before the first 1 are ignored. That 1 is the start bit. The next two bits are the opcode (10 read, 01 write, 11 erase, 00 special). The address follows, with WORD_AW bits in word mode and WORD_AW+1 bits in byte mode.
- R2: Under opcode 00, the two most significant address bits select the command: 11 sets the enable latch, 00 clears it, 10 erases the whole array and 01 writes the whole array. The other address bits have no effect.
- R3: With `org_word` high, locations are 16 bits and word w is made of byte 2w (bits 7:0) and byte 2w+1 (bits 15:8). With `org_word` low, locations are single bytes. Data fields are 16 or 8 bits, shifted most significant bit first.
- R4: After the last address bit of a read, `sdo_oe` is high and `sdo` shows the most significant bit of the addressed location. Each later rising `sck` edge advances one bit. After the last bit, the next location follows, with the address wrapping from the top location to 0.
- R5: A write replaces the whole location, with no prior erase needed. An erase sets the location to all ones. Erase-all sets every location to all ones. Write-all stores the data field in every location.
- R6: A program command (write, erase, erase-all, write-all) has an effect only if the enable latch is set and `prog_en` is high when the command is launched. Otherwise the array is unchanged and no busy status appears.
- R7: Commands take effect when `cs` falls after the last required bit. If `cs` falls earlier, the command is dropped with no effect.
- R8: While a program cycle runs and `cs` is high, `sdo_oe` is 1 and `sdo` is 0. Once the cycle ends, `sdo` is 1 until `cs` goes low or a new start bit arrives. Read, enable and disable commands produce no status.
- R9: Busy lasts T_CELL clocks for a write or erase, T_ERAL for erase-all and T_WRAL for write-all. Start bits arriving while busy are ignored.
- R10: After reset every location reads all ones, the enable latch is clear and `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock, rising edge samples `sdi` |
| sdi | input | 1 | Serial data in |
| org_word | input | 1 | 1: 16-bit locations, 0: 8-bit locations |
| prog_en | input | 1 | 0 blocks all program commands |
| sdo | output | 1 | Serial data out / ready-busy status |
| sdo_oe | output | 1 | Output enable for `sdo` (0 = high impedance) |

## Verification
The hardest case to reach from the ports is a command arriving while a program cycle is still running. The bench launches a write-all with a long busy time. While the device is still busy, it shifts a complete erase command and drops chip select. It then waits for the cycle to end and reads the target location back to show that the erase never happened. Aborted and protected commands are checked the same way: at the status output right after launch, and then by reading the array back.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam logic [1:0] OPC_SPECIAL = 2'b00;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_READ    = 2'b10;
    localparam logic [1:0] OPC_ERASE   = 2'b11;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_READ,
        CMD_WRITE,
        CMD_ERASE,
        CMD_ERAL,
        CMD_WRAL,
        CMD_EWEN,
        CMD_EWDS
    } cmd_e;

    typedef enum logic [2:0] {
        FE_IDLE,
        FE_HDR,
        FE_DATA,
        FE_READ,
        FE_DONE
    } fe_state_e;

    function automatic cmd_e decode_cmd(input logic [1:0] opc, input logic [1:0] ext);
        cmd_e c;
        case (opc)
            OPC_READ:  c = CMD_READ;
            OPC_WRITE: c = CMD_WRITE;
            OPC_ERASE: c = CMD_ERASE;
            default: begin
                case (ext)
                    2'b11:   c = CMD_EWEN;
                    2'b10:   c = CMD_ERAL;
                    2'b01:   c = CMD_WRAL;
                    default: c = CMD_EWDS;
                endcase
            end
        endcase
        return c;
    endfunction

    function automatic logic is_program(input cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_ERAL) || (c == CMD_WRAL);
    endfunction

    function automatic logic needs_data(input cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_WRAL);
    endfunction

endpackage

// File: rtl/mw_frontend.sv
module mw_frontend
    import mw_pkg::*;
#(
    parameter int WORD_AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs,
    input  logic               sck,
    input  logic               sdi,
    input  logic               org_word,
    input  logic               hold,
    output logic               start_evt,
    output logic               exec,
    output cmd_e               exec_cmd,
    output logic [WORD_AW:0]   exec_addr,
    output logic [15:0]        exec_data,
    output logic               rd_load,
    output logic               rd_shift,
    output logic               rd_active
);
    localparam int AWM = WORD_AW + 1;
    localparam int CW  = $clog2(AWM + 18);

    fe_state_e         state;
    logic              sck_q;
    logic              rise;
    logic [CW-1:0]     cnt;
    logic [1:0]        opc;
    logic [AWM-1:0]    asr;
    logic [AWM-1:0]    a_full;
    logic [1:0]        ext;
    logic [CW-1:0]     hdr_last;
    logic [CW-1:0]     dat_last;
    cmd_e              dec;

    assign rise     = sck & ~sck_q;
    assign hdr_last = org_word ? CW'(WORD_AW + 1) : CW'(AWM + 1);
    assign dat_last = org_word ? CW'(15) : CW'(7);
    assign a_full   = {asr[AWM-2:0], sdi};
    assign ext      = org_word ? a_full[WORD_AW-1 -: 2] : a_full[AWM-1 -: 2];
    assign dec      = decode_cmd(opc, ext);
    assign rd_active = (state == FE_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= FE_IDLE;
            sck_q     <= 1'b0;
            cnt       <= '0;
            opc       <= '0;
            asr       <= '0;
            exec      <= 1'b0;
            exec_cmd  <= CMD_NONE;
            exec_addr <= '0;
            exec_data <= '0;
            rd_load   <= 1'b0;
            rd_shift  <= 1'b0;
            start_evt <= 1'b0;
        end else begin
            sck_q     <= sck;
            exec      <= 1'b0;
            rd_load   <= 1'b0;
            rd_shift  <= 1'b0;
            start_evt <= 1'b0;
            if (!cs) begin
                if (state == FE_DONE) exec <= 1'b1;
                state <= FE_IDLE;
            end else if (rise) begin
                case (state)
                    FE_IDLE: begin
                        if (sdi && !hold) begin
                            state     <= FE_HDR;
                            cnt       <= '0;
                            asr       <= '0;
                            start_evt <= 1'b1;
                        end
                    end
                    FE_HDR: begin
                        cnt <= cnt + 1'b1;
                        if (cnt < CW'(2)) opc <= {opc[0], sdi};
                        else              asr <= a_full;
                        if (cnt == hdr_last) begin
                            cnt       <= '0;
                            exec_addr <= a_full;
                            exec_cmd  <= dec;
                            if (dec == CMD_READ) begin
                                state   <= FE_READ;
                                rd_load <= 1'b1;
                            end else if (needs_data(dec)) begin
                                state <= FE_DATA;
                            end else begin
                                state <= FE_DONE;
                            end
                        end
                    end
                    FE_DATA: begin
                        exec_data <= {exec_data[14:0], sdi};
                        cnt       <= cnt + 1'b1;
                        if (cnt == dat_last) state <= FE_DONE;
                    end
                    FE_READ: rd_shift <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // R1: a read load pulse only appears together with entry into streaming
    a_r1_read_entry: assert property (@(posedge clk) disable iff (rst)
        rd_load |-> rd_active);

    // R9: no command is launched while a program cycle runs
    a_r9_no_exec_busy: assert property (@(posedge clk) disable iff (rst)
        hold |-> !exec);

endmodule

// File: rtl/mw_readout.sv
module mw_readout
    import mw_pkg::*;
#(
    parameter int WORD_AW = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             org_word,
    input  logic             rd_load,
    input  logic             rd_shift,
    input  logic [WORD_AW:0] load_addr,
    input  logic [15:0]      rdata,
    output logic [WORD_AW:0] peek_addr,
    output logic             rd_bit
);
    localparam int AWM = WORD_AW + 1;

    logic [AWM-1:0] ra;
    logic [AWM-1:0] ra_inc;
    logic [AWM-1:0] ra_next;
    logic [15:0]    sh;
    logic [15:0]    aligned;
    logic [3:0]     bcnt;
    logic [3:0]     last_bit;

    assign ra_inc    = ra + 1'b1;
    assign ra_next   = org_word ? {1'b0, ra_inc[WORD_AW-1:0]} : ra_inc;
    assign peek_addr = rd_load ? load_addr : ra_next;
    assign aligned   = org_word ? rdata : {rdata[7:0], 8'h00};
    assign last_bit  = org_word ? 4'd15 : 4'd7;
    assign rd_bit    = sh[15];

    always_ff @(posedge clk) begin
        if (rst) begin
            ra   <= '0;
            sh   <= '0;
            bcnt <= '0;
        end else if (rd_load) begin
            ra   <= load_addr;
            sh   <= aligned;
            bcnt <= '0;
        end else if (rd_shift) begin
            if (bcnt == last_bit) begin
                ra   <= ra_next;
                sh   <= aligned;
                bcnt <= '0;
            end else begin
                sh   <= {sh[14:0], 1'b0};
                bcnt <= bcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mw_cell_array.sv
module mw_cell_array
    import mw_pkg::*;
#(
    parameter int WORD_AW = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             org_word,
    input  logic [WORD_AW:0] rd_addr,
    output logic [15:0]      rdata,
    input  logic             op_valid,
    input  cmd_e             op_cmd,
    input  logic [WORD_AW:0] op_addr,
    input  logic [15:0]      op_data
);
    localparam int AWM = WORD_AW + 1;
    localparam int NB  = 2 ** AWM;

    logic [7:0]     mem [NB];
    logic [AWM-1:0] rd_lo, rd_hi, op_lo, op_hi;

    assign rd_lo = {rd_addr[WORD_AW-1:0], 1'b0};
    assign rd_hi = {rd_addr[WORD_AW-1:0], 1'b1};
    assign op_lo = {op_addr[WORD_AW-1:0], 1'b0};
    assign op_hi = {op_addr[WORD_AW-1:0], 1'b1};

    assign rdata = org_word ? {mem[rd_hi], mem[rd_lo]} : {8'h00, mem[rd_addr]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
        end else if (op_valid) begin
            case (op_cmd)
                CMD_WRITE: begin
                    if (org_word) begin
                        mem[op_lo] <= op_data[7:0];
                        mem[op_hi] <= op_data[15:8];
                    end else begin
                        mem[op_addr] <= op_data[7:0];
                    end
                end
                CMD_ERASE: begin
                    if (org_word) begin
                        mem[op_lo] <= 8'hFF;
                        mem[op_hi] <= 8'hFF;
                    end else begin
                        mem[op_addr] <= 8'hFF;
                    end
                end
                CMD_ERAL: begin
                    for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
                end
                CMD_WRAL: begin
                    for (int i = 0; i < NB; i++)
                        mem[i] <= (org_word && i[0]) ? op_data[15:8] : op_data[7:0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer
    import mw_pkg::*;
#(
    parameter int T_CELL = 500000,
    parameter int T_ERAL = 1500000,
    parameter int T_WRAL = 3000000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  cmd_e sel,
    output logic busy
);
    localparam int TMAX = (T_WRAL > T_ERAL) ? ((T_WRAL > T_CELL) ? T_WRAL : T_CELL)
                                            : ((T_ERAL > T_CELL) ? T_ERAL : T_CELL);
    localparam int CW = $clog2(TMAX + 1);

    logic [CW-1:0] count;
    logic [CW-1:0] load;

    always_comb begin
        case (sel)
            CMD_ERAL: load = CW'(T_ERAL);
            CMD_WRAL: load = CW'(T_WRAL);
            default:  load = CW'(T_CELL);
        endcase
    end

    assign busy = (count != '0);

    always_ff @(posedge clk) begin
        if (rst)           count <= '0;
        else if (start)    count <= load;
        else if (busy)     count <= count - 1'b1;
    end

    // R9: a new cycle only starts from idle
    a_r9_start_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R9: once busy, the device stays busy for at least one more clock
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int WORD_AW = 10,
    parameter int T_CELL  = 500000,
    parameter int T_ERAL  = 1500000,
    parameter int T_WRAL  = 3000000
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sck,
    input  logic sdi,
    input  logic org_word,
    input  logic prog_en,
    output logic sdo,
    output logic sdo_oe
);
    logic             start_evt;
    logic             exec;
    cmd_e             exec_cmd;
    logic [WORD_AW:0] exec_addr;
    logic [15:0]      exec_data;
    logic             rd_load, rd_shift, rd_active, rd_bit;
    logic [WORD_AW:0] peek_addr;
    logic [15:0]      rdata;
    logic             busy;
    logic             launch;
    logic             wen_q;
    logic             status_pend;

    mw_frontend #(.WORD_AW(WORD_AW)) u_front (
        .clk(clk), .rst(rst), .cs(cs), .sck(sck), .sdi(sdi),
        .org_word(org_word), .hold(busy),
        .start_evt(start_evt), .exec(exec), .exec_cmd(exec_cmd),
        .exec_addr(exec_addr), .exec_data(exec_data),
        .rd_load(rd_load), .rd_shift(rd_shift), .rd_active(rd_active)
    );

    mw_readout #(.WORD_AW(WORD_AW)) u_read (
        .clk(clk), .rst(rst), .org_word(org_word),
        .rd_load(rd_load), .rd_shift(rd_shift), .load_addr(exec_addr),
        .rdata(rdata), .peek_addr(peek_addr), .rd_bit(rd_bit)
    );

    mw_cell_array #(.WORD_AW(WORD_AW)) u_array (
        .clk(clk), .rst(rst), .org_word(org_word),
        .rd_addr(peek_addr), .rdata(rdata),
        .op_valid(launch), .op_cmd(exec_cmd),
        .op_addr(exec_addr), .op_data(exec_data)
    );

    mw_busy_timer #(.T_CELL(T_CELL), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)) u_timer (
        .clk(clk), .rst(rst), .start(launch), .sel(exec_cmd), .busy(busy)
    );

    assign launch = exec && is_program(exec_cmd) && wen_q && prog_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            wen_q       <= 1'b0;
            status_pend <= 1'b0;
        end else begin
            if (exec && exec_cmd == CMD_EWEN) wen_q <= 1'b1;
            if (exec && exec_cmd == CMD_EWDS) wen_q <= 1'b0;
            if (launch)                          status_pend <= 1'b1;
            else if (start_evt || (!cs && !busy)) status_pend <= 1'b0;
        end
    end

    assign sdo_oe = rd_active | (cs & status_pend);
    assign sdo    = rd_active ? rd_bit : ~busy;

    // R6: a program cycle only begins after an allowed launch
    a_r6_guarded_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(wen_q) && $past(prog_en)));

    // R7: dropping chip select ends read streaming
    a_r7_cs_ends_read: assert property (@(posedge clk) disable iff (rst)
        $fell(cs) |=> !rd_active);

    // R8: read streaming never overlaps a program cycle
    a_r8_no_read_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rd_active);

    // R10: reset clears the enable latch and the status phase
    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (!wen_q && !status_pend));

endmodule

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
    localparam int WAW = 4;
    localparam int TC  = 20;
    localparam int TE  = 50;
    localparam int TW  = 100;
    localparam int NBY = 2 ** (WAW + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, sck = 1'b0, sdi = 1'b0, org_word = 1'b1, prog_en = 1'b1;
    logic sdo, sdo_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [NBY];

    mw_eeprom #(.WORD_AW(WAW), .T_CELL(TC), .T_ERAL(TE), .T_WRAL(TW)) dut (
        .clk(clk), .rst(rst), .cs(cs), .sck(sck), .sdi(sdi),
        .org_word(org_word), .prog_en(prog_en), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int aw(input logic org);
        return org ? WAW : WAW + 1;
    endfunction

    task automatic clk_bit(input logic b, output logic obs);
        obs = sdo;
        sdi = b;
        tick(2);
        sck = 1'b1;
        tick(3);
        sck = 1'b0;
        tick(3);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            logic o;
            clk_bit(v[i], o);
        end
    endtask

    task automatic begin_cmd(input logic [1:0] opc, input logic [31:0] addr);
        cs = 1'b1;
        tick(2);
        send_bits(32'd1, 1);
        send_bits({30'd0, opc}, 2);
        send_bits(addr, aw(org_word));
    endtask

    task automatic end_cmd();
        cs = 1'b0;
        sdi = 1'b0;
        tick(4);
    endtask

    task automatic launch(output int busy_len, output logic ready_seen, output logic oe_seen);
        cs = 1'b0;
        sdi = 1'b0;
        tick(2);
        cs = 1'b1;
        #1;
        oe_seen = sdo_oe;
        busy_len = 0;
        while (sdo_oe && !sdo && busy_len < 1000) begin
            busy_len++;
            tick(1);
        end
        #1;
        ready_seen = sdo_oe && sdo;
        cs = 1'b0;
        tick(4);
    endtask

    function automatic logic [31:0] special_addr(input logic [1:0] ext);
        return 32'(ext) << (aw(org_word) - 2);
    endfunction

    function automatic logic [15:0] expect_loc(input int a);
        if (org_word) return {model[2*a+1], model[2*a]};
        return {8'h00, model[a]};
    endfunction

    task automatic read_seq(input string req, input int a, input int n);
        int dw = org_word ? 16 : 8;
        int nloc = org_word ? (NBY / 2) : NBY;
        begin_cmd(2'b10, 32'(a));
        #1;
        check({req, " oe during read"}, 32'(sdo_oe), 32'd1);
        for (int k = 0; k < n; k++) begin
            logic [15:0] w = '0;
            for (int b = 0; b < dw; b++) begin
                logic o;
                clk_bit(1'b0, o);
                w = {w[14:0], o};
            end
            check(req, 32'(w), 32'(expect_loc((a + k) % nloc)));
        end
        end_cmd();
    endtask

    task automatic special(input logic [1:0] ext);
        begin_cmd(2'b00, special_addr(ext));
    endtask

    task automatic model_write(input int a, input logic [15:0] d);
        if (org_word) begin
            model[2*a]   = d[7:0];
            model[2*a+1] = d[15:8];
        end else begin
            model[a] = d[7:0];
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bl;
        logic rdy, oe;
        for (int i = 0; i < NBY; i++) model[i] = 8'hFF;
        tick(4);
        rst = 1'b0;
        tick(2);

        // R10: reset state
        check("R10 sdo_oe after reset", 32'(sdo_oe), 32'd0);
        read_seq("R10 erased after reset", 0, 2);

        // R6: latch clear after reset, write ignored
        begin_cmd(2'b01, 32'd3);
        send_bits(32'hBEEF, 16);
        launch(bl, rdy, oe);
        check("R6 no status without enable", 32'(oe), 32'd0);
        read_seq("R6 location unchanged", 3, 1);

        // R2, R8: enable latch, no status after it
        special(2'b11);
        send_bits(32'h0, 0);
        launch(bl, rdy, oe);
        check("R8 no status after enable cmd", 32'(oe), 32'd0);

        // R5, R9, R3: write every word, measure busy time
        for (int w = 0; w < NBY / 2; w++) begin
            logic [15:0] d = 16'(w * 16'h1357) ^ 16'hC0DE;
            begin_cmd(2'b01, 32'(w));
            send_bits(32'(d), 16);
            launch(bl, rdy, oe);
            model_write(w, d);
            check("R8 busy status enabled", 32'(oe), 32'd1);
            check("R9 write busy length", 32'((bl >= TC - 1) && (bl <= TC + 1)), 32'd1);
            check("R8 ready after cycle", 32'(rdy), 32'd1);
        end
        // R4: full sequential read with wrap
        read_seq("R4 sequential word read", 0, NBY / 2 + 1);
        read_seq("R4 word wrap from top", NBY / 2 - 1, 2);

        // R3: byte view of the same contents
        org_word = 1'b0;
        tick(2);
        read_seq("R3 byte order", 0, NBY + 1);
        // R5: byte write and byte erase
        begin_cmd(2'b01, 32'd9);
        send_bits(32'h5A, 8);
        launch(bl, rdy, oe);
        model_write(9, 16'h005A);
        check("R9 byte write busy", 32'((bl >= TC - 1) && (bl <= TC + 1)), 32'd1);
        begin_cmd(2'b11, 32'd10);
        launch(bl, rdy, oe);
        model_write(10, 16'h00FF);
        read_seq("R5 byte write/erase", 8, 4);
        org_word = 1'b1;
        tick(2);
        read_seq("R3 word of bytes 8,9", 4, 2);

        // R5: word erase
        begin_cmd(2'b11, 32'd6);
        launch(bl, rdy, oe);
        model_write(6, 16'hFFFF);
        read_seq("R5 word erase", 6, 1);

        // R6: pin-level protect
        prog_en = 1'b0;
        begin_cmd(2'b01, 32'd7);
        send_bits(32'h0000, 16);
        launch(bl, rdy, oe);
        check("R6 no status when protected", 32'(oe), 32'd0);
        read_seq("R6 protected location", 7, 1);
        prog_en = 1'b1;

        // R2, R6: disable latch then write ignored
        special(2'b00);
        launch(bl, rdy, oe);
        begin_cmd(2'b01, 32'd7);
        send_bits(32'h0000, 16);
        launch(bl, rdy, oe);
        check("R2 disable blocks write", 32'(oe), 32'd0);
        read_seq("R2 location kept after disable", 7, 1);
        special(2'b11);
        launch(bl, rdy, oe);

        // R7: abort mid data
        begin_cmd(2'b01, 32'd2);
        send_bits(32'h00, 8);
        launch(bl, rdy, oe);
        check("R7 no status on abort", 32'(oe), 32'd0);
        read_seq("R7 aborted write", 2, 1);

        // R1: leading zeros before the start bit
        cs = 1'b1;
        tick(2);
        send_bits(32'd0, 3);
        send_bits(32'd1, 1);
        send_bits(32'b10, 2);
        send_bits(32'd5, WAW);
        begin
            logic [15:0] w = '0;
            for (int b = 0; b < 16; b++) begin
                logic o;
                clk_bit(1'b0, o);
                w = {w[14:0], o};
            end
            check("R1 leading zeros ignored", 32'(w), 32'(expect_loc(5)));
        end
        end_cmd();

        // R5, R9: erase-all
        special(2'b10);
        launch(bl, rdy, oe);
        for (int i = 0; i < NBY; i++) model[i] = 8'hFF;
        check("R9 erase-all busy", 32'((bl >= TE - 1) && (bl <= TE + 1)), 32'd1);
        read_seq("R5 erase-all", 0, NBY / 2);

        // R5, R9: write-all
        special(2'b01);
        send_bits(32'h1234, 16);
        launch(bl, rdy, oe);
        for (int i = 0; i < NBY; i++) model[i] = i[0] ? 8'h12 : 8'h34;
        check("R9 write-all busy", 32'((bl >= TW - 1) && (bl <= TW + 1)), 32'd1);
        read_seq("R5 write-all", 0, NBY / 2);

        // R9: command during a running cycle is ignored
        special(2'b01);
        send_bits(32'h1234, 16);
        cs = 1'b0;
        tick(2);
        begin_cmd(2'b11, 32'd5);
        end_cmd();
        tick(TW + 20);
        read_seq("R9 erase ignored while busy", 5, 1);

        // R2: don't-care low address bits on a special command
        org_word = 1'b0;
        tick(2);
        begin_cmd(2'b00, special_addr(2'b10) | 32'h5);
        launch(bl, rdy, oe);
        for (int i = 0; i < NBY; i++) model[i] = 8'hFF;
        check("R2 erase-all with don't-care bits", 32'((bl >= TE - 1) && (bl <= TE + 1)), 32'd1);
        read_seq("R2 byte erase-all result", 0, 4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule